// File: doc/BRIEF.md
# Opcode-Driven Two's-Complement Arithmetic Unit

This block is a purely combinational two's-complement arithmetic unit of parameterised width. A 3-bit function code picks one of five operations: add, subtract, add with carry, negate and increment. All five run on one shared binary adder. The first adder operand is the x input, bit-inverted when the code asks for it. The second adder operand is either the y input, bit-inverted on request, or a vector of zeros. The adder carry-in is derived from the function code and, for add with carry, from the cin input.

The outputs are the N-bit result and four flags. The flags are the carry out of the top adder position, the sign of the result, a zero indication and signed overflow. Function codes that name no operation give an all-zero result with quiet flags. A surrounding datapath can therefore leave the code at an unused value without spurious flag activity.

Top module: `au_twos_alu`

## Requirements
- R1: Code 3'b001 (add) gives z = (x + y) mod 2^N, with cout set when x + y, taken unsigned, reaches 2^N; cin has no effect.
- R2: Code 3'b011 (subtract) gives z = (x - y) mod 2^N, computed as x + ~y + 1, so cout is set exactly when x >= y unsigned.
- R3: Code 3'b101 (add with carry) gives z = (x + y + cin) mod 2^N, with cout set when that unsigned sum reaches 2^N.
- R4: Code 3'b110 (change sign) gives z = (-x) mod 2^N, computed as ~x + 1, so cout is set only for x = 0; y and cin have no effect.
- R5: Code 3'b010 (increment) gives z = (x + 1) mod 2^N, with cout set only for x all ones; y and cin have no effect.
- R6: For every code, sgn equals bit N-1 of z, and zero is set exactly when every bit of z is 0.
- R7: ovf is set exactly when the signed result of the selected operation lies outside -2^(N-1) .. 2^(N-1)-1. Under change sign this happens only for x = -2^(N-1); under increment only for x = 2^(N-1)-1.
- R8: Codes 3'b000, 3'b100 and 3'b111 give z = 0, cout = 0, ovf = 0, sgn = 0 and zero = 1, whatever x, y and cin are.
- R9: Outputs depend only on the current inputs, with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | N | First operand, two's complement |
| y | input | N | Second operand, two's complement |
| cin | input | 1 | Carry input, used only by add with carry |
| fcode | input | 3 | Function code selecting the operation |
| z | output | N | Result |
| cout | output | 1 | Carry out of the most significant adder position |
| sgn | output | 1 | Sign of the result |
| zero | output | 1 | Result is all zeros |
| ovf | output | 1 | Signed overflow |

## Verification
The bench targets the most negative value under change sign. A unit that derives overflow from operand signs alone, rather than from the adder's own operands, would miss the overflow there, and a missing +1 would return the wrong magnitude. It also drives subtract with equal operands and with every pairing of zero, one, the signed extremes and all ones. Here a wrong carry-in or an uninverted y shows up at once as a wrong cout or a false overflow. Increment and add are run with random cin and y, to catch a carry-in equation that leaks cin into codes that must ignore it. The three unused codes are driven with random operands; a unit that let the adder through would show x, or x + y, on z.

// File: rtl/au_pkg.sv
// Package au_pkg
// Shared function-code constants and the control bundle passed from the
// decoder to the datapath of the arithmetic unit. Assumes a 3-bit code.
package au_pkg;

    localparam logic [2:0] FC_ADD  = 3'b001;
    localparam logic [2:0] FC_SUB  = 3'b011;
    localparam logic [2:0] FC_ADDC = 3'b101;
    localparam logic [2:0] FC_NEG  = 3'b110;
    localparam logic [2:0] FC_INC  = 3'b010;

    typedef struct packed {
        logic inv_x;     // bit-invert the x operand
        logic inv_y;     // bit-invert the y operand
        logic use_y;     // 1: y path feeds adder, 0: zeros feed adder
        logic carry_in;  // adder carry into bit 0
        logic legal;     // code names a defined operation
    } au_ctl_t;

endpackage

// File: rtl/au_decode.sv
// Module au_decode
// Turns the 3-bit function code into the datapath controls. The inversion,
// select and carry-in equations are shared by all codes; a separate legal
// bit marks the three codes that name no operation. Pure combinational.
module au_decode
    import au_pkg::*;
(
    input  logic [2:0] fcode,
    input  logic       cin,
    output au_ctl_t    ctl
);

    // Derive the adder controls from the code bits.
    always_comb begin
        ctl.inv_x    = fcode[2] & fcode[1];
        ctl.inv_y    = fcode[1];
        ctl.use_y    = fcode[0];
        ctl.carry_in = fcode[1] | (fcode[2] & fcode[0] & cin);
        unique case (fcode)
            FC_ADD, FC_SUB, FC_ADDC, FC_NEG, FC_INC: ctl.legal = 1'b1;
            default:                                 ctl.legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/au_operand_cond.sv
// Module au_operand_cond
// Conditional bit-inversion of one operand followed by a choice between
// that value and zeros. Used for both adder inputs; the x path ties
// pass high. Assumes WIDTH >= 1.
module au_operand_cond #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic             invert,
    input  logic             pass,
    output logic [WIDTH-1:0] q
);

    // Invert on request, then gate to zero when the path is not selected.
    always_comb begin
        q = pass ? (a ^ {WIDTH{invert}}) : '0;
    end

endmodule

// File: rtl/au_ripple_adder.sv
// Module au_ripple_adder
// WIDTH-bit carry-ripple adder built from per-bit propagate/generate
// cells. Exposes the carry into and out of the top position so that the
// flag logic can derive signed overflow. Assumes WIDTH >= 2.
module au_ripple_adder #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             c_in,
    output logic [WIDTH-1:0] sum,
    output logic             c_top_in,
    output logic             c_out
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] carry;

    assign carry[0] = c_in;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic prop;
        logic gen;
        // One full-adder cell: propagate, generate, sum and carry.
        always_comb begin
            prop         = op_a[i] ^ op_b[i];
            gen          = op_a[i] & op_b[i];
            sum[i]       = prop ^ carry[i];
            carry[i + 1] = gen | (prop & carry[i]);
        end
    end

    assign c_top_in = carry[MSB];
    assign c_out    = carry[WIDTH];

endmodule

// File: rtl/au_flags.sv
// Module au_flags
// Forms the result and the four status flags from the adder outputs.
// When the code is not legal every output is forced to its quiet value
// (result zero, zero flag set). Overflow is taken from the carries into
// and out of the top bit. Assumes WIDTH >= 2.
module au_flags #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] sum,
    input  logic             c_top_in,
    input  logic             c_out,
    input  logic             legal,
    output logic [WIDTH-1:0] z,
    output logic             cout,
    output logic             sgn,
    output logic             zero,
    output logic             ovf
);

    localparam int MSB = WIDTH - 1;

    // Gate the adder result and derive flags from the gated value.
    always_comb begin
        z    = legal ? sum : '0;
        cout = legal & c_out;
        ovf  = legal & (c_out ^ c_top_in);
        sgn  = z[MSB];
        zero = ~|z;
    end

endmodule

// File: rtl/au_twos_alu.sv
// Module au_twos_alu
// Combinational two's-complement arithmetic unit: add, subtract, add with
// carry, change sign and increment, all on one shared adder. Unused
// function codes return zero with quiet flags. Assumes N >= 2.
module au_twos_alu
    import au_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0] x,
    input  logic [N-1:0] y,
    input  logic         cin,
    input  logic [2:0]   fcode,
    output logic [N-1:0] z,
    output logic         cout,
    output logic         sgn,
    output logic         zero,
    output logic         ovf
);

    localparam int MSB = N - 1;

    au_ctl_t      ctl;
    logic [N-1:0] opnd_a;
    logic [N-1:0] opnd_b;
    logic [N-1:0] sum;
    logic         c_top_in;
    logic         c_out;

    au_decode u_decode (
        .fcode (fcode),
        .cin   (cin),
        .ctl   (ctl)
    );

    au_operand_cond #(.WIDTH(N)) u_cond_x (
        .a      (x),
        .invert (ctl.inv_x),
        .pass   (1'b1),
        .q      (opnd_a)
    );

    au_operand_cond #(.WIDTH(N)) u_cond_y (
        .a      (y),
        .invert (ctl.inv_y),
        .pass   (ctl.use_y),
        .q      (opnd_b)
    );

    au_ripple_adder #(.WIDTH(N)) u_adder (
        .op_a     (opnd_a),
        .op_b     (opnd_b),
        .c_in     (ctl.carry_in),
        .sum      (sum),
        .c_top_in (c_top_in),
        .c_out    (c_out)
    );

    au_flags #(.WIDTH(N)) u_flags (
        .sum      (sum),
        .c_top_in (c_top_in),
        .c_out    (c_out),
        .legal    (ctl.legal),
        .z        (z),
        .cout     (cout),
        .sgn      (sgn),
        .zero     (zero),
        .ovf      (ovf)
    );

    // Port-level consistency checks between the code and the outputs.
    always_comb begin
        if (fcode == 3'b000 || fcode == 3'b100 || fcode == 3'b111)
            AST_UNUSED_QUIET: assert (z == '0 && !cout && !ovf && zero && !sgn); // R8
        if (fcode == FC_SUB && x == y)
            AST_SUB_SELF_ZERO: assert (zero && cout && !ovf); // R2
        if (fcode == FC_INC && x == '1)
            AST_INC_WRAP: assert (zero && cout && !ovf); // R5
        if (fcode == FC_NEG && x == '0)
            AST_NEG_OF_ZERO: assert (zero && cout); // R4
        if (fcode == FC_ADD && x[MSB] != y[MSB])
            AST_NO_OVF_MIXED_SIGNS: assert (!ovf); // R7
        if (zero)
            AST_ZERO_NOT_NEG: assert (!sgn); // R6
    end

endmodule

// File: tb/test_au_twos_alu.sv
// Bench for au_twos_alu: a behavioural integer reference is compared with
// the outputs on every clock. Inputs change after the rising edge and are
// sampled at the falling edge.
module test_au_twos_alu;

    localparam int    W          = 16;
    localparam time   CLK_PERIOD = 10ns;
    localparam longint MODV      = longint'(1) << W;
    localparam longint SMAX      = (longint'(1) << (W - 1)) - 1;
    localparam longint SMIN      = -(longint'(1) << (W - 1));

    logic         clk = 1'b0;
    logic [W-1:0] x = '0;
    logic [W-1:0] y = '0;
    logic         cin = 1'b0;
    logic [2:0]   fcode = 3'b000;
    logic [W-1:0] z;
    logic         cout, sgn, zero, ovf;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    au_twos_alu #(.N(W)) i_au_twos_alu (
        .x     (x),
        .y     (y),
        .cin   (cin),
        .fcode (fcode),
        .z     (z),
        .cout  (cout),
        .sgn   (sgn),
        .zero  (zero),
        .ovf   (ovf)
    );

    task automatic chk(input string tag, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h (fcode=%b x=%h y=%h cin=%b)",
                     tag, what, act, exp, fcode, x, y, cin);
        end
    endtask

    // Apply one vector and compare against the integer reference.
    task automatic run_vec(input logic [2:0] op, input logic [W-1:0] a,
                           input logic [W-1:0] b, input logic ci);
        longint ua = longint'(a);
        longint ub = longint'(b);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint full = 0;
        longint tru  = 0;
        bit     legal = 1'b1;
        string  tag;
        logic [W-1:0] ez;
        logic ecout, eovf, esgn, ezero;
        case (op)
            3'b001: begin full = ua + ub;                tru = sa + sb;      tag = "R1"; end
            3'b011: begin full = ua + (MODV - 1 - ub) + 1; tru = sa - sb;    tag = "R2"; end
            3'b101: begin full = ua + ub + longint'(ci); tru = sa + sb + longint'(ci); tag = "R3"; end
            3'b110: begin full = (MODV - 1 - ua) + 1;    tru = -sa;          tag = "R4"; end
            3'b010: begin full = ua + 1;                 tru = sa + 1;       tag = "R5"; end
            default: begin legal = 1'b0;                                     tag = "R8"; end
        endcase
        if (legal) begin
            ez    = W'(full % MODV);
            ecout = (full >= MODV);
            eovf  = (tru > SMAX) || (tru < SMIN);
        end else begin
            ez    = '0;
            ecout = 1'b0;
            eovf  = 1'b0;
        end
        esgn  = ez[W-1];
        ezero = (ez == '0);
        @(posedge clk);
        fcode = op; x = a; y = b; cin = ci;
        @(negedge clk);
        chk(tag, "z", longint'(z), longint'(ez));
        chk(tag, "cout", longint'(cout), longint'(ecout));
        chk(legal ? "R6" : "R8", "sgn", longint'(sgn), longint'(esgn));
        chk(legal ? "R6" : "R8", "zero", longint'(zero), longint'(ezero));
        chk(legal ? "R7" : "R8", "ovf", longint'(ovf), longint'(eovf));
    endtask

    logic [W-1:0] edge_vals [5];

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        edge_vals[0] = '0;
        edge_vals[1] = W'(1);
        edge_vals[2] = {1'b0, {(W-1){1'b1}}};
        edge_vals[3] = {1'b1, {(W-1){1'b0}}};
        edge_vals[4] = '1;

        // Initial state: unused code with zero inputs, R8 and R9.
        @(negedge clk);
        chk("R8", "initial z", longint'(z), 0);
        chk("R8", "initial zero", longint'(zero), 1);

        // Boundary pairs under every code, both cin values (R1..R8).
        for (int op = 0; op < 8; op++)
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++)
                    for (int c = 0; c < 2; c++)
                        run_vec(3'(op), edge_vals[i], edge_vals[j], c[0]);

        // R4: most negative value under change sign must overflow.
        run_vec(3'b110, {1'b1, {(W-1){1'b0}}}, '0, 1'b0);
        // R2: equal operands under subtract.
        run_vec(3'b011, W'(16'h1234), W'(16'h1234), 1'b1);
        // R5: increment of largest positive value overflows.
        run_vec(3'b010, {1'b0, {(W-1){1'b1}}}, '1, 1'b1);

        // Random operands under every code, random cin (R1..R9).
        for (int k = 0; k < 3000; k++)
            run_vec(3'($urandom_range(7, 0)), W'($urandom), W'($urandom), 1'($urandom));

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule